// File: doc/BRIEF.md
# Direction-Flag Circular FIFO Buffer

This block is a single-clock first-in/first-out buffer placed between a producing and a consuming subsystem. Its storage is a dual-port RAM used as a ring. One address counter points at the next slot to write and another at the oldest unread slot. Each counter steps forward by one on every accepted operation. When it steps past the last location it returns to zero.

When the two counters hold the same value, the ring is either completely full or completely empty. The block tells these apart with a one-bit direction register instead of an extra pointer bit or an occupancy counter. The register records whether the most recent unbalanced cycle added an entry or removed one. The full and empty flags are registered. Read data comes from a synchronous RAM read and appears one cycle after an accepted read request.

Top module: `dirflag_fifo`

## Requirements
- R1: After a synchronous active-high reset, empty is 1 and full is 0, and rd_data is 0.
- R2: Data leaves in the order it entered. The word for an accepted read appears on rd_data after the clock edge that samples rd_en = 1. rd_data keeps that value until the next accepted read.
- R3: A write without a read sets the direction to adding. full is 1 exactly when the direction is adding and the two addresses match. With a depth of 2^ADDR_W, full rises after 2^ADDR_W net writes.
- R4: A read without a write sets the direction to removing. empty is 1 exactly when the direction is removing and the addresses match.
- R5: A write request while full, with no read in the same cycle, is ignored. Stored contents, addresses and flags are unchanged.
- R6: A read request while empty, with or without a write in the same cycle, is not accepted. rd_data holds its previous value.
- R7: While full, a write and a read in the same cycle are both accepted. The direction is kept, full stays 1, and the order of the data is preserved.
- R8: While empty, a write and a read in the same cycle accept only the write. empty falls after that edge.
- R9: Both address counters wrap from 2^ADDR_W-1 to 0. A long stream of mixed traffic keeps its order across many wraps.
- R10: full and empty are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Buffer holds 2^ADDR_W words |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Oldest word, registered |
| empty | output | 1 | Buffer holds no words |

## Verification
The hardest case to reach is a write and a read in the same cycle while the two addresses are equal. When the buffer is full, the write lands on the very slot being read. That read has to return the old word, and the direction must not change. The stimulus first fills the ring to exactly 2^ADDR_W entries and then holds both requests high for several cycles. It then drains the buffer to empty and issues simultaneous requests there too. A queue-based model predicts every popped word and both flags through these cycles.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  typedef enum logic {
    DIR_REMOVING = 1'b0,
    DIR_ADDING   = 1'b1
  } dir_e;
endpackage

// File: rtl/dfifo_addr_ctr.sv
module dfifo_addr_ctr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  // A power-of-two depth lets the counter wrap by plain overflow.
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (step) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/dfifo_dir_ctrl.sv
module dfifo_dir_ctrl
  import dfifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ADDR_W-1:0] raddr,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              full,
  output logic              empty
);
  dir_e              dir_q, dir_d;
  logic [ADDR_W-1:0] waddr_nxt, raddr_nxt;
  logic              same_nxt;

  // A read is taken whenever data exists. A write is taken when room
  // exists, or when a read in the same cycle frees a slot.
  always_comb begin
    rd_ok = rd_req & ~empty;
    wr_ok = wr_req & (~full | rd_ok);
  end

  always_comb begin
    dir_d = dir_q;
    if (wr_ok && !rd_ok)      dir_d = DIR_ADDING;
    else if (rd_ok && !wr_ok) dir_d = DIR_REMOVING;
  end

  always_comb begin
    waddr_nxt = waddr + {{(ADDR_W-1){1'b0}}, wr_ok};
    raddr_nxt = raddr + {{(ADDR_W-1){1'b0}}, rd_ok};
    same_nxt  = (waddr_nxt == raddr_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_REMOVING;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      dir_q <= dir_d;
      full  <= same_nxt && (dir_d == DIR_ADDING);
      empty <= same_nxt && (dir_d == DIR_REMOVING);
    end
  end
endmodule

// File: rtl/dfifo_ram.sv
module dfifo_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // The read port is read-first. A read that hits the slot being written
  // in the same cycle returns the old word.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dirflag_fifo.sv
module dirflag_fifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_ok, rd_ok;

  dfifo_dir_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_req(wr_en), .rd_req(rd_en),
    .waddr(waddr), .raddr(raddr), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .full(full), .empty(empty)
  );

  dfifo_addr_ctr #(.ADDR_W(ADDR_W)) u_wctr (
    .clk(clk), .rst(rst), .step(wr_ok), .addr(waddr)
  );

  dfifo_addr_ctr #(.ADDR_W(ADDR_W)) u_rctr (
    .clk(clk), .rst(rst), .step(rd_ok), .addr(raddr)
  );

  dfifo_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst(rst), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .re(rd_ok), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/dirflag_fifo_chk.sv
module dirflag_fifo_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full,
  input logic              empty,
  input logic [DATA_W-1:0] rd_data
);
  a_r10_never_both: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  a_r1_empty_after_reset: assert property (@(posedge clk)
    rst |=> (empty && !full));

  a_r5_full_holds_on_lone_write: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> full);

  a_r6_empty_read_keeps_data: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data)));

  a_r7_full_both_stays_full: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && rd_en) |=> full);

  a_r8_empty_both_fills: assert property (@(posedge clk) disable iff (rst)
    (empty && wr_en && rd_en) |=> (!empty && $stable(rd_data)));
endmodule

bind dirflag_fifo dirflag_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .empty(empty), .rd_data(rd_data)
);

// File: tb/dirflag_fifo_bench.sv
module dirflag_fifo_bench;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              full, empty;
  logic [DATA_W-1:0] rd_data;

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";

  logic [DATA_W-1:0] sb[$];
  logic [DATA_W-1:0] last_pop = '0;
  logic [DATA_W-1:0] next_word = 16'hA000;

  always #10 clk = ~clk;

  dirflag_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dirflag_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // The model advances on each edge, using the inputs the design sampled there.
  always @(posedge clk) begin
    if (rst) begin
      sb.delete();
      last_pop <= '0;
    end else begin
      automatic bit r_ok = rd_en && (sb.size() > 0);
      automatic bit w_ok = wr_en && ((sb.size() < DEPTH) || r_ok);
      if (r_ok) last_pop <= sb.pop_front();
      if (w_ok) sb.push_back(wr_data);
    end
  end

  // The monitor checks outputs half a cycle after each edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(rd_data == last_pop, {tag, " rd_data (R2 order)"}, rd_data, last_pop);
      chk(full == (sb.size() == DEPTH), {tag, " full (R3)"}, full, sb.size() == DEPTH);
      chk(empty == (sb.size() == 0), {tag, " empty (R4)"}, empty, sb.size() == 0);
      chk(!(full && empty), "R10 flags exclusive", {full, empty}, 0);
    end
  end

  // The driver changes the inputs on the falling edge, one cycle per call.
  task automatic cyc(input logic w, input logic r);
    @(negedge clk);
    wr_en   = w;
    rd_en   = r;
    wr_data = next_word;
    if (w) next_word = next_word + 16'h0101;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    chk(empty == 1'b1, "R1 empty after reset", empty, 1);
    chk(full == 1'b0, "R1 full after reset", full, 0);
    chk(rd_data == '0, "R1 rd_data after reset", rd_data, 0);

    tag = "R2";
    for (int i = 0; i < 3; i++) cyc(1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1);

    tag = "R3";
    for (int i = 0; i < DEPTH; i++) cyc(1, 0);
    cyc(0, 0);
    @(negedge clk);
    chk(full == 1'b1, "R3 full after DEPTH writes", full, 1);

    tag = "R5";
    for (int i = 0; i < 3; i++) cyc(1, 0);

    tag = "R7";
    for (int i = 0; i < 4; i++) cyc(1, 1);
    cyc(0, 0);
    @(negedge clk);
    chk(full == 1'b1, "R7 still full after paired ops", full, 1);

    tag = "R4";
    for (int i = 0; i < DEPTH; i++) cyc(0, 1);
    cyc(0, 0);
    @(negedge clk);
    chk(empty == 1'b1, "R4 empty after drain", empty, 1);

    tag = "R6";
    for (int i = 0; i < 3; i++) cyc(0, 1);

    tag = "R8";
    cyc(1, 1);
    cyc(0, 0);
    @(negedge clk);
    chk(empty == 1'b0, "R8 write taken while empty", empty, 0);
    cyc(0, 1);

    tag = "R9";
    for (int i = 0; i < 120; i++) cyc((i % 3) != 0, (i % 2) == 0);
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 1);
    cyc(0, 0);
    @(negedge clk);
    chk(empty == 1'b1, "R9 empty after wrap stream", empty, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule